// File: doc/BRIEF.md
# Polled Multi-Port Cell Transmit Master

This block is the cell-source end of a shared transmit bus that feeds several PHY ports. Each PHY port has its own upstream byte stream into the block. The block stores one complete fixed-length cell per port. While any cell is stored or a transfer is running, it steps a poll address through the port numbers on `tadr`. Two clocks after each poll it records the shared `tpxa` flag as that port's ready bit.

When a port both holds a full cell and has its ready bit set, the block spends one clock selecting the port. In that clock `ten_n` is high and the port's address is on `tadr`. The cell's bytes then follow on `tdata` with `ten_n` low, and `tsox` marks the first byte. Polling continues on `tadr` during the transfer. When the last byte of a cell is sent and another port is eligible, the select clock for that port follows at once. When ports compete, the lowest port number is served first.

Top module: `cell_tx_master`

## Requirements
- R1: While any port holds a full cell or a transfer is active, every clock that is not a select clock puts the next poll address on `tadr`, counting 0,1,..,NPORT-1 and wrapping to 0. This also applies during cell bytes.
- R2: The `tpxa` value sampled at the second rising edge after a poll address is driven becomes that port's ready bit. A select clears the selected port's ready bit.
- R3: A transfer starts with exactly one select clock: `ten_n`=1 and the port number on `tadr`. On the next clock `ten_n`=0, `tsox`=1 and `tdata` carries byte 0 of that port's cell.
- R4: A cell is CELL_LEN (default 53) consecutive bytes with `ten_n`=0, in the order they were received. `tsox` is 1 only with byte 0.
- R5: No cell is sent to a port whose last sampled `tpxa` was 0. Its cell stays stored until a later poll reports it ready.
- R6: A synchronous reset (`rst`=1) gives `ten_n`=1, `tsox`=0 and `tadr`=idle code, with no port selected and no cell stored.
- R7: If another port is eligible when the last byte of a cell is sent, that port's select clock comes directly after the last byte, with a single `ten_n`-high clock between the two cells.
- R8: When no cell is stored and no transfer is active, `tadr` carries the idle code (all ones, 7 for ADDR_W=3) and `ten_n` stays 1.
- R9: On the upstream side, a byte with `in_sof` set becomes byte 0 of a new cell. Bytes without `in_sof` that arrive before any start are discarded. `in_ready[p]` is 0 while port p holds a complete cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Per-port upstream byte valid |
| in_sof | input | NPORT | Per-port start-of-cell flag for the current byte |
| in_data | input | NPORT*8 | Per-port upstream bytes, port p at bits [8p+7:8p] |
| in_ready | output | NPORT | Per-port upstream ready |
| tadr | output | ADDR_W | Poll or select address |
| tpxa | input | 1 | PHY cell-space reply to a poll two clocks earlier |
| ten_n | output | 1 | Transmit enable, active low |
| tsox | output | 1 | First-byte-of-cell marker |
| tdata | output | 8 | Cell byte |

## Verification
The checker tests the framing on every clock. `tsox` only appears with `ten_n` low and lasts a single clock. Every falling edge of `ten_n` carries `tsox`. Back-to-back enabled clocks advance the poll address by one. Reset leaves the bus idle. Only the bench scenarios can show the rest, because it needs a PHY model that answers polls with a two-clock delay and per-port expected queues. That covers byte order and cell length per port, a cell held back from a port that reports no space, the single-clock gap between consecutive cells, and discarded bytes that arrive before a start of cell.

// File: rtl/cell_tx_master.sv
module cell_tx_master #(
  parameter int NPORT    = 4,
  parameter int ADDR_W   = 3,
  parameter int CELL_LEN = 53
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORT-1:0]     in_valid,
  input  logic [NPORT-1:0]     in_sof,
  input  logic [NPORT*8-1:0]   in_data,
  output logic [NPORT-1:0]     in_ready,
  output logic [ADDR_W-1:0]    tadr,
  input  logic                 tpxa,
  output logic                 ten_n,
  output logic                 tsox,
  output logic [7:0]           tdata
);
  localparam int CW = $clog2(CELL_LEN + 1);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [ADDR_W-1:0] IDLE_ADR = '1;

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_XFER} st_t;
  st_t st;

  logic [7:0]    cbuf [NPORT][CELL_LEN];
  logic [CW-1:0] wp [NPORT];
  logic [NPORT-1:0] full, rdy;
  logic [PW-1:0] cur, pptr, pick, pa0, pa1;
  logic          pv0, pv1, found;
  logic [CW-1:0] cnt;

  assign in_ready = ~full;
  wire last    = (st == S_XFER) && (cnt == CW'(CELL_LEN));
  wire sel_go  = found && ((st == S_IDLE) || last);
  wire poll_en = (|full) || (st != S_IDLE);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (rdy[i] && full[i] && !(st == S_XFER && cur == PW'(i))) begin
        found = 1'b1;
        pick  = PW'(i);
      end
  end

  always_ff @(posedge clk)
    for (int p = 0; p < NPORT; p++)
      if (in_valid[p] && !full[p]) begin
        if (in_sof[p]) cbuf[p][0] <= in_data[p*8 +: 8];
        else if (wp[p] != '0) cbuf[p][wp[p]] <= in_data[p*8 +: 8];
      end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= '0;
      for (int p = 0; p < NPORT; p++) wp[p] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (in_valid[p] && !full[p]) begin
          if (in_sof[p]) wp[p] <= CW'(1);
          else if (wp[p] != '0) begin
            if (wp[p] == CW'(CELL_LEN - 1)) begin
              full[p] <= 1'b1;
              wp[p]   <= '0;
            end else wp[p] <= wp[p] + 1'b1;
          end
        end
      if (last) full[cur] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv0 <= 1'b0; pv1 <= 1'b0; pa0 <= '0; pa1 <= '0;
      pptr <= '0; rdy <= '0;
    end else begin
      pv1 <= pv0;
      pa1 <= pa0;
      if (!sel_go && poll_en) begin
        pv0  <= 1'b1;
        pa0  <= pptr;
        pptr <= (pptr == PW'(NPORT - 1)) ? '0 : pptr + 1'b1;
      end else pv0 <= 1'b0;
      if (pv1) rdy[pa1] <= tpxa;
      if (sel_go) rdy[pick] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; cnt <= '0;
      ten_n <= 1'b1; tsox <= 1'b0; tdata <= '0; tadr <= IDLE_ADR;
    end else begin
      tadr <= sel_go ? ADDR_W'(pick) : poll_en ? ADDR_W'(pptr) : IDLE_ADR;
      case (st)
        S_IDLE:
          if (sel_go) begin
            st  <= S_SEL;
            cur <= pick;
          end
        S_SEL: begin
          st    <= S_XFER;
          ten_n <= 1'b0;
          tsox  <= 1'b1;
          tdata <= cbuf[cur][0];
          cnt   <= CW'(1);
        end
        default:
          if (!last) begin
            tsox  <= 1'b0;
            tdata <= cbuf[cur][cnt];
            cnt   <= cnt + 1'b1;
          end else begin
            ten_n <= 1'b1;
            tsox  <= 1'b0;
            tdata <= '0;
            if (sel_go) begin
              st  <= S_SEL;
              cur <= pick;
            end else st <= S_IDLE;
          end
      endcase
    end
  end
endmodule

module cell_tx_master_chk #(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ten_n,
  input logic              tsox,
  input logic [ADDR_W-1:0] tadr
);
  assert_sox_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    tsox |-> !ten_n);
  assert_enable_starts_cell_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ten_n) |-> tsox);
  assert_sox_single_R4: assert property (@(posedge clk) disable iff (rst)
    tsox |=> !tsox);
  assert_poll_steps_R1: assert property (@(posedge clk) disable iff (rst)
    (!ten_n && $past(!ten_n)) |-> (int'(tadr) == (int'($past(tadr)) + 1) % NPORT));
  assert_reset_idle_R6: assert property (@(posedge clk)
    rst |=> (ten_n && !tsox && tadr == '1));
endmodule

bind cell_tx_master cell_tx_master_chk #(.NPORT(NPORT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ten_n(ten_n), .tsox(tsox), .tadr(tadr));

// File: tb/test_cell_tx_master.sv
module test_cell_tx_master;
  localparam int NP = 4, AW = 3, CL = 53;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] in_valid = '0, in_sof = '0, in_ready;
  logic [NP*8-1:0] in_data = '0;
  logic [AW-1:0] tadr;
  logic tpxa = 1'b0, ten_n, tsox;
  logic [7:0] tdata;

  always #10 clk = ~clk;

  cell_tx_master #(.NPORT(NP), .ADDR_W(AW), .CELL_LEN(CL)) i_cell_tx_master (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .in_ready(in_ready), .tadr(tadr), .tpxa(tpxa), .ten_n(ten_n), .tsox(tsox), .tdata(tdata));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expq [NP][$];
  logic [NP-1:0] phy_rdy = 4'b1011;
  int starts [NP];
  int last_gap = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // PHY model: reply to the address driven two edges ago
  int d1 = 7, d2 = 7;
  always @(negedge clk) begin
    d2 = d1;
    d1 = int'(tadr);
    tpxa = (d2 < NP) ? phy_rdy[d2] : 1'b0;
  end

  // Monitor
  int sel = 0, cur = 0, idx = 0, hi_run = 0, prev_adr = 0;
  bit in_cell = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!ten_n) begin
        if (tsox) begin
          chk(hi_run == 1 || !in_cell, "R3 select clocks before cell", hi_run, 1);
          chk(sel < NP, "R3 select address", sel, 0);
          cur = sel; idx = 0; in_cell = 1; last_gap = hi_run;
          if (sel < NP) starts[sel]++;
        end else if (idx >= 1) begin
          chk(int'(tadr) == (prev_adr + 1) % NP, "R1 poll step in transfer", int'(tadr), (prev_adr + 1) % NP);
        end
        chk(tsox == (idx == 0), "R4 tsox only on byte 0", int'(tsox), int'(idx == 0));
        if (cur < NP && expq[cur].size() > 0) begin
          logic [7:0] e;
          e = expq[cur].pop_front();
          chk(tdata == e, "R4 cell byte", int'(tdata), int'(e));
        end else chk(0, "R4 unexpected byte", int'(tdata), -1);
        idx++;
        prev_adr = int'(tadr);
        hi_run = 0;
      end else begin
        if (in_cell) begin
          chk(idx == CL, "R4 cell length", idx, CL);
          in_cell = 0;
        end
        hi_run++;
        sel = int'(tadr);
      end
    end
  end

  task automatic load_cell(input int p, input int seed, input int junk);
    for (int i = 0; i < junk + CL; i++) begin
      @(negedge clk);
      while (!in_ready[p]) @(negedge clk);
      in_valid[p] = 1'b1;
      in_sof[p]   = (i == junk);
      in_data[p*8 +: 8] = (i < junk) ? 8'hEE : 8'(seed + (i - junk) * 7);
      @(posedge clk);
      #1;
      in_valid[p] = 1'b0;
      in_sof[p]   = 1'b0;
    end
    for (int k = 0; k < CL; k++) expq[p].push_back(8'(seed + k * 7));
  endtask

  task automatic wait_empty(input int p, input string tag);
    int t = 0;
    while ((expq[p].size() != 0 || in_cell) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(expq[p].size() == 0, tag, expq[p].size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) starts[p] = 0;
    repeat (4) @(negedge clk);
    chk(ten_n == 1'b1, "R6 reset ten_n", int'(ten_n), 1);
    chk(tsox == 1'b0, "R6 reset tsox", int'(tsox), 0);
    chk(tadr == 3'd7, "R6 reset tadr idle", int'(tadr), 7);
    chk(in_ready == 4'hF, "R6 reset no cell stored", int'(in_ready), 15);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(tadr == 3'd7 && ten_n, "R8 idle code with nothing stored", int'(tadr), 7);

    load_cell(0, 10, 0);
    wait_empty(0, "R3 R4 port 0 cell delivered");

    load_cell(3, 100, 3);
    wait_empty(3, "R9 junk before sof discarded, port 3 cell intact");

    load_cell(2, 55, 0);
    repeat (2) @(negedge clk);
    chk(in_ready[2] == 1'b0, "R9 in_ready low while cell stored", int'(in_ready[2]), 0);
    repeat (300) @(negedge clk);
    chk(expq[2].size() == CL, "R5 R2 cell held for not-ready port", expq[2].size(), CL);
    chk(starts[2] == 0, "R5 no start to not-ready port", starts[2], 0);

    phy_rdy[0] = 1'b0;
    phy_rdy[1] = 1'b0;
    repeat (10) @(negedge clk);
    load_cell(0, 200, 0);
    load_cell(1, 33, 0);
    repeat (20) @(negedge clk);
    chk(starts[0] == 1 && starts[1] == 0, "R2 no start while ready bits clear", starts[0] + starts[1], 1);
    phy_rdy[0] = 1'b1;
    phy_rdy[1] = 1'b1;
    wait_empty(0, "R7 first of pair delivered");
    wait_empty(1, "R7 second of pair delivered");
    chk(last_gap == 1, "R7 single select clock between cells", last_gap, 1);

    phy_rdy[2] = 1'b1;
    wait_empty(2, "R5 held cell sent once port ready");
    chk(starts[2] == 1, "R5 one start to port 2", starts[2], 1);

    repeat (10) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk(tadr == 3'd7 && ten_n == 1'b1, "R8 idle code after drain", int'(tadr), 7);
      @(negedge clk);
    end
    finish_run();
  end
endmodule